// File: doc/BRIEF.md
# Segmented approximate adder

This block adds two unsigned operands while limiting how far any carry may travel. The operands are cut into segments: the least significant segment holds whatever bits are left over after the upper bits are grouped into full segments, and each of the other segments is `SEG` bits wide. Because the carry is cut at every segment boundary, the worst-case logic depth is set by the segment width rather than by the operand width. The price is an occasional error in the upper bits. It is meant for datapaths that tolerate small arithmetic errors, such as filtering, pixel blending and accumulation of noisy samples.

A one-bit mode input chooses how each segment obtains its carry-in. In isolated mode every segment adds with a carry-in of zero, so no carry crosses a boundary and the longest chain is one segment. In linked mode a separate carry generator looks at the bits of the segment immediately below, assuming a zero carry into that lower segment. Its carry-out becomes the carry-in of the current segment's sum generator. A carry can therefore span at most two segments, which makes this mode more accurate. The block is purely combinational.

Top module: `seg_approx_adder`

## Requirements
- R1: With `modeSel` = 0, the sum bits of every segment equal the segment's two operand slices added modulo 2^(segment width), with no carry taken from any lower segment.
- R2: With `modeSel` = 0, `carryOut` is the carry produced by the top segment's operand slices alone.
- R3: With `modeSel` = 1, the lowest segment takes carry-in 0. Every other segment takes as carry-in the carry that the segment directly below produces from its own operand slices with carry-in 0.
- R4: With `modeSel` = 1, `carryOut` is the carry-out of the top segment's sum generator, which includes that segment's predicted carry-in.
- R5: In both modes the bits of the lowest segment (width `WIDTH - (ceil(WIDTH/SEG)-1)*SEG`) equal the low bits of the exact sum.
- R6: In both modes the value {`carryOut`, `sumOut`} never exceeds the exact (WIDTH+1)-bit sum of the operands.
- R7: With `modeSel` = 1, the result equals the exact sum whenever no segment below the top one has every bit position in the propagate state (operand bits differ).
- R8: With `modeSel` = 0, the result equals the exact sum whenever no segment below the top one produces a carry from its own operand slices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| modeSel | input | 1 | 0 = isolated segments, 1 = carry predicted from the segment below |
| sumOut | output | WIDTH | Approximate sum bits |
| carryOut | output | 1 | Carry out of the top segment |

## Verification
Each operand pair is applied in both modes to two configurations at once: one where the width divides evenly into segments, and one with a narrower leftover lowest segment. Operand pairs whose bits are all in the propagate state expose errors that come only from mispredicted carries in linked mode. Pairs such as all-ones plus one create a long chain that crosses every boundary, and show how isolated and linked modes drop different carries. Random operands and near-complement operands then compare every result with a behavioural segment model and with the exact sum. This confirms the upper bound and the exactness conditions for carry-free and non-propagating inputs.

// File: rtl/seg_adder_pkg.sv
`timescale 1ns/1ps
package seg_adder_pkg;

  typedef enum logic {
    MODE_ISOLATED = 1'b0,
    MODE_LINKED   = 1'b1
  } addMode_e;

  typedef struct packed {
    logic carryLinkEn;
  } ctlStrobe_t;

  function automatic int segCount(input int w, input int s);
    return (w + s - 1) / s;
  endfunction

  function automatic int lowSize(input int w, input int s);
    return w - (segCount(w, s) - 1) * s;
  endfunction

  function automatic int segBase(input int w, input int s, input int g);
    return (g == 0) ? 0 : lowSize(w, s) + (g - 1) * s;
  endfunction

  function automatic int segSize(input int w, input int s, input int g);
    return (g == 0) ? lowSize(w, s) : s;
  endfunction

endpackage

// File: rtl/seg_carry_gen.sv
`timescale 1ns/1ps
module seg_carry_gen #(
  parameter int SZ = 4
) (
  input  logic [SZ-1:0] a,
  input  logic [SZ-1:0] b,
  output logic          cout
);
  logic chain;

  always_comb begin
    chain = 1'b0;
    for (int j = 0; j < SZ; j++) begin
      chain = (a[j] & b[j]) | ((a[j] ^ b[j]) & chain);
    end
    cout = chain;
  end
endmodule

// File: rtl/seg_sum_gen.sv
`timescale 1ns/1ps
module seg_sum_gen #(
  parameter int SZ        = 4,
  parameter int CARRY_OUT = 0
) (
  input  logic [SZ-1:0]           a,
  input  logic [SZ-1:0]           b,
  input  logic                    cin,
  output logic [SZ+CARRY_OUT-1:0] res
);
  localparam int OW = SZ + CARRY_OUT;

  assign res = OW'(a) + OW'(b) + OW'(cin);
endmodule

// File: rtl/seg_path.sv
`timescale 1ns/1ps
module seg_path
  import seg_adder_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG   = 6
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctlStrobe_t       strobe,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int NSEG = segCount(WIDTH, SEG);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int BASE = segBase(WIDTH, SEG, g);
    localparam int SZ   = segSize(WIDTH, SEG, g);
    localparam bit TOP  = (g == NSEG - 1);
    logic segCin;

    if (g == 0) begin : g_first
      assign segCin = 1'b0;
    end else begin : g_pred
      localparam int PBASE = segBase(WIDTH, SEG, g - 1);
      localparam int PSZ   = segSize(WIDTH, SEG, g - 1);
      logic lowGen;
      seg_carry_gen #(.SZ(PSZ)) u_cgen (
        .a    (opA[PBASE +: PSZ]),
        .b    (opB[PBASE +: PSZ]),
        .cout (lowGen)
      );
      assign segCin = strobe.carryLinkEn & lowGen;
    end

    if (TOP) begin : g_top
      logic [SZ:0] topRes;
      seg_sum_gen #(.SZ(SZ), .CARRY_OUT(1)) u_sgen (
        .a   (opA[BASE +: SZ]),
        .b   (opB[BASE +: SZ]),
        .cin (segCin),
        .res (topRes)
      );
      assign sumOut[BASE +: SZ] = topRes[SZ-1:0];
      assign carryOut           = topRes[SZ];
    end else begin : g_mid
      seg_sum_gen #(.SZ(SZ), .CARRY_OUT(0)) u_sgen (
        .a   (opA[BASE +: SZ]),
        .b   (opB[BASE +: SZ]),
        .cin (segCin),
        .res (sumOut[BASE +: SZ])
      );
    end
  end
endmodule

// File: rtl/seg_ctrl.sv
`timescale 1ns/1ps
module seg_ctrl
  import seg_adder_pkg::*;
(
  input  logic       modeSel,
  output ctlStrobe_t strobe
);
  addMode_e mode;

  assign mode = addMode_e'(modeSel);

  always_comb begin
    strobe.carryLinkEn = (mode == MODE_LINKED);
  end
endmodule

// File: rtl/seg_approx_adder.sv
`timescale 1ns/1ps
module seg_approx_adder
  import seg_adder_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG   = 6
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             modeSel,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  ctlStrobe_t strobe;

  seg_ctrl u_ctrl (
    .modeSel (modeSel),
    .strobe  (strobe)
  );

  seg_path #(.WIDTH(WIDTH), .SEG(SEG)) u_path (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/seg_approx_adder_chk.sv
`timescale 1ns/1ps
module seg_approx_adder_chk
  import seg_adder_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG   = 6
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             modeSel,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);
  localparam int NSEG = segCount(WIDTH, SEG);
  localparam int LOW  = lowSize(WIDTH, SEG);

  logic [WIDTH:0]  exact;
  logic [WIDTH:0]  approx;
  logic [NSEG-1:0] fullProp;
  logic [NSEG-1:0] ownGen;
  logic            known;

  assign exact  = (WIDTH+1)'(opA) + (WIDTH+1)'(opB);
  assign approx = {carryOut, sumOut};
  assign known  = !$isunknown({opA, opB, modeSel, sumOut, carryOut});

  assign fullProp[NSEG-1] = 1'b0;
  assign ownGen[NSEG-1]   = 1'b0;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int BASE = segBase(WIDTH, SEG, g);
    localparam int SZ   = segSize(WIDTH, SEG, g);

    if (g < NSEG - 1) begin : g_low
      logic c;
      assign fullProp[g] = &(opA[BASE +: SZ] ^ opB[BASE +: SZ]);
      always_comb begin
        c = 1'b0;
        for (int j = 0; j < SZ; j++) begin
          c = (opA[BASE+j] & opB[BASE+j]) | ((opA[BASE+j] ^ opB[BASE+j]) & c);
        end
      end
      assign ownGen[g] = c;
    end

    always_comb begin
      if (known && !modeSel) begin
        // R1
        iso_segment_chk: assert (sumOut[BASE +: SZ] == opA[BASE +: SZ] + opB[BASE +: SZ])
          else $error("isolated segment %0d sum mismatch", g);
      end
    end
  end

  always_comb begin
    if (known) begin
      // R5
      low_seg_exact_chk: assert (sumOut[LOW-1:0] == exact[LOW-1:0])
        else $error("lowest segment not exact");
      // R6
      no_overshoot_chk: assert (approx <= exact)
        else $error("approximate sum above exact sum");
      // R7
      linked_exact_chk: assert (!(modeSel && !(|fullProp)) || approx == exact)
        else $error("linked mode inexact without full-propagate segment");
      // R8
      isolated_exact_chk: assert (!(!modeSel && !(|ownGen)) || approx == exact)
        else $error("isolated mode inexact without boundary carry");
    end
  end
endmodule

bind seg_approx_adder seg_approx_adder_chk #(.WIDTH(WIDTH), .SEG(SEG)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .modeSel  (modeSel),
  .sumOut   (sumOut),
  .carryOut (carryOut)
);

// File: tb/test_seg_approx_adder.sv
`timescale 1ns/1ps
module test_seg_approx_adder;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic modeSel = 1'b0;
  logic [W-1:0] sumA, sumB;
  logic coA, coB;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_approx_adder #(.WIDTH(W), .SEG(6)) i_seg_approx_adder (
    .opA(opA), .opB(opB), .modeSel(modeSel), .sumOut(sumA), .carryOut(coA));

  seg_approx_adder #(.WIDTH(W), .SEG(4)) i_seg_approx_adder_even (
    .opA(opA), .opB(opB), .modeSel(modeSel), .sumOut(sumB), .carryOut(coB));

  function automatic int nSeg(input int s);
    return (W + s - 1) / s;
  endfunction

  function automatic int lowW(input int s);
    return W - (nSeg(s) - 1) * s;
  endfunction

  // Behavioural segment model: walks segments from the bottom up.
  function automatic longint model(input longint a, input longint b, input int mode, input int s);
    longint res = 0;
    longint cin = 0;
    longint topC = 0;
    int pos = 0;
    for (int i = 0; i < nSeg(s); i++) begin
      int sz = (i == 0) ? lowW(s) : s;
      longint mask = (64'd1 << sz) - 1;
      longint sa = (a >> pos) & mask;
      longint sb = (b >> pos) & mask;
      longint t = sa + sb + ((mode != 0) ? cin : 0);
      res |= (t & mask) << pos;
      topC = (t >> sz) & 1;
      cin = ((sa + sb) >> sz) & 1;
      pos += sz;
    end
    return res | (topC << W);
  endfunction

  function automatic bit anyFullProp(input longint a, input longint b, input int s);
    int pos = 0;
    for (int i = 0; i < nSeg(s) - 1; i++) begin
      int sz = (i == 0) ? lowW(s) : s;
      longint mask = (64'd1 << sz) - 1;
      if ((((a ^ b) >> pos) & mask) == mask) return 1'b1;
      pos += sz;
    end
    return 1'b0;
  endfunction

  function automatic bit anyOwnCarry(input longint a, input longint b, input int s);
    int pos = 0;
    for (int i = 0; i < nSeg(s) - 1; i++) begin
      int sz = (i == 0) ? lowW(s) : s;
      longint mask = (64'd1 << sz) - 1;
      if (((((a >> pos) & mask) + ((b >> pos) & mask)) >> sz) != 0) return 1'b1;
      pos += sz;
    end
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic m,
                       output longint rA, output longint rB);
    @(posedge clk);
    opA = a;
    opB = b;
    modeSel = m;
    @(negedge clk);
    rA = longint'({coA, sumA});
    rB = longint'({coB, sumB});
  endtask

  task automatic checkCfg(input longint a, input longint b, input int s,
                          input longint r0, input longint r1);
    longint ex = a + b;
    longint lm = (64'd1 << lowW(s)) - 1;
    longint e0 = model(a, b, 0, s);
    longint e1 = model(a, b, 1, s);
    chk(r0 == e0, "R1 R2 isolated", r0, e0);
    chk(r1 == e1, "R3 R4 linked", r1, e1);
    chk((r0 & lm) == (ex & lm), "R5 low isolated", r0 & lm, ex & lm);
    chk((r1 & lm) == (ex & lm), "R5 low linked", r1 & lm, ex & lm);
    chk(r0 <= ex, "R6 isolated bound", r0, ex);
    chk(r1 <= ex, "R6 linked bound", r1, ex);
    if (!anyFullProp(a, b, s)) chk(r1 == ex, "R7 linked exact", r1, ex);
    if (!anyOwnCarry(a, b, s)) chk(r0 == ex, "R8 isolated exact", r0, ex);
  endtask

  task automatic runPair(input logic [W-1:0] a, input logic [W-1:0] b);
    longint rA0, rB0, rA1, rB1;
    apply(a, b, 1'b0, rA0, rB0);
    apply(a, b, 1'b1, rA1, rB1);
    checkCfg(longint'(a), longint'(b), 6, rA0, rA1);
    checkCfg(longint'(a), longint'(b), 4, rB0, rB1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({coA, sumA} == '0, "R5 zero operands", longint'({coA, sumA}), 0);
    chk({coB, sumB} == '0, "R5 zero operands", longint'({coB, sumB}), 0);
    rst = 1'b0;

    runPair(16'h0000, 16'h0000);
    runPair(16'hFFFF, 16'h0001);   // chain through every boundary
    runPair(16'hAAAA, 16'h5555);   // all propagate, no carry anywhere
    runPair(16'h8000, 16'h8000);   // carry only out of the top
    runPair(16'hFFFF, 16'hFFFF);
    runPair(16'h0F0F, 16'h00F1);
    runPair(16'h003F, 16'h0001);
    runPair(16'h03F0, 16'h0010);
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a = W'($urandom);
      logic [W-1:0] b = (i % 2 == 0) ? W'($urandom) : (~a ^ W'(1 << (i % W)));
      runPair(a, b);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule